// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write side of a parallel flash controller and turns a stream of bus write cycles into command strobes. Each accepted write carries an address and a data byte. Most commands are guarded by a two-cycle unlock pair: AA at the primary command address, then 55 at the secondary address. The decoder follows these multi-cycle sequences and emits a single strobe when one completes. The strobe names the command and carries the address and data of the final cycle. A few commands take a single cycle: erase suspend, resume, and the short form of identification exit.

The decoder also has a fast-program mode. Once it is entered, every accepted write is a program command, whatever its data. In this mode the erase, suspend, resume and exit codes are programmed as data and do not act as commands. Only reset leaves the mode. A level flag tracks whether identification mode is active. While the array reports busy, writes are dropped and the sequence position is kept.

The write stream has a valid but no ready. The block never applies back-pressure: a write presented with `wr_valid` high is consumed on that edge. When `busy` is high the write is consumed and discarded. The command output is a valid-qualified stream with no ready, so the consumer must take each strobe in the cycle it appears.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `cmd_valid`, `id_mode` and `bypass_mode` are 0.
- R2: A program command is AA@5555, 55@2AAA, A0@5555, then a write to any address. It gives a strobe of kind 1 carrying that fourth write's address and data.
- R3: A sector erase is AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, then 30 at any address. It gives a strobe of kind 2 carrying that address.
- R4: The same five-cycle prefix followed by 10@5555 gives a chip-erase strobe of kind 3.
- R5: The same five-cycle prefix followed by 40 at any address gives a sector-lockout strobe of kind 4 carrying that address.
- R6: AA@5555, 55@2AAA, 90@5555 gives kind 5 and sets `id_mode`. Two forms clear `id_mode` and give kind 6: AA@5555, 55@2AAA, F0@5555, or a single F0 written to any address from idle.
- R7: From idle, a single B0 at any address gives an erase-suspend strobe of kind 7. A single 30 gives a resume strobe of kind 8 carrying the plane address written.
- R8: The five-cycle prefix followed by A0@5555 sets `bypass_mode` with no strobe. From then on, every accepted write gives kind 1 with its own address and data, including B0, 30, 80, F0 and AA. Only reset clears `bypass_mode`.
- R9: A write presented while `busy` is 1 gives no strobe and leaves the sequence position and both mode flags unchanged.
- R10: A write that does not match the next step of a sequence in progress returns the decoder to idle without a strobe. Such a write does not start a single-cycle command.
- R11: A strobe is a one-cycle `cmd_valid` pulse in the cycle after the edge that accepted the completing write. `cmd_kind` is 1 to 8 as listed in R2 to R8, and no strobe appears without an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A write cycle is presented |
| wr_addr | input | AW (16) | Write address |
| wr_data | input | DW (8) | Write data; bits 7:0 are decoded |
| busy | input | 1 | An embedded operation is running; writes are dropped |
| cmd_valid | output | 1 | Command strobe |
| cmd_kind | output | 4 | Command code, 1 to 8 |
| cmd_addr | output | AW (16) | Address of the completing write |
| cmd_data | output | DW (8) | Data of the completing write |
| id_mode | output | 1 | Identification mode is active |
| bypass_mode | output | 1 | Every write is a program command |

## Verification
Every result is registered once. A strobe, the change of `id_mode` and the setting of `bypass_mode` all appear in the cycle after the edge that accepts the write that causes them. The bench drives each write on the falling clock edge. It compares all outputs at the following falling edge, one full period later, and then presents the next write. A bench reference model, advanced once per presented write, supplies the expected values for both the directed sequences and the biased random stream.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    CMD_NONE       = 4'd0,
    CMD_PROGRAM    = 4'd1,
    CMD_SECT_ERASE = 4'd2,
    CMD_CHIP_ERASE = 4'd3,
    CMD_LOCKOUT    = 4'd4,
    CMD_ID_ENTER   = 4'd5,
    CMD_ID_EXIT    = 4'd6,
    CMD_SUSPEND    = 4'd7,
    CMD_RESUME     = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PAIR1,
    SQ_PAIR2,
    SQ_PGM,
    SQ_SETUP,
    SQ_PAIR3,
    SQ_PAIR4
  } seq_e;

  localparam logic [7:0] CODE_KEY_A    = 8'hAA;
  localparam logic [7:0] CODE_KEY_B    = 8'h55;
  localparam logic [7:0] CODE_PROGRAM  = 8'hA0;
  localparam logic [7:0] CODE_SETUP    = 8'h80;
  localparam logic [7:0] CODE_ID_ENTER = 8'h90;
  localparam logic [7:0] CODE_EXIT     = 8'hF0;
  localparam logic [7:0] CODE_SECTOR   = 8'h30;
  localparam logic [7:0] CODE_CHIP     = 8'h10;
  localparam logic [7:0] CODE_LOCK     = 8'h40;
  localparam logic [7:0] CODE_SUSPEND  = 8'hB0;

  typedef struct packed {
    logic       key_a;
    logic       key_b;
    logic       at_cmd;
    logic [7:0] code;
  } cyc_t;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] ADDR_CMD = 16'h5555,
  parameter logic [AW-1:0] ADDR_ALT = 16'h2AAA
) (
  input  logic [AW-1:0] addr,
  input  logic [7:0]    code,
  output cyc_t          cyc
);

  logic hit_cmd;
  logic hit_alt;

  assign hit_cmd = (addr == ADDR_CMD);
  assign hit_alt = (addr == ADDR_ALT);

  always_comb begin
    cyc.at_cmd = hit_cmd;
    cyc.key_a  = hit_cmd && (code == CODE_KEY_A);
    cyc.key_b  = hit_alt && (code == CODE_KEY_B);
    cyc.code   = code;
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  cyc_t cyc,
  output cmd_e hit_kind,
  output logic bypass
);

  seq_e st_q, st_d;
  logic byp_set;

  always_comb begin
    st_d     = st_q;
    hit_kind = CMD_NONE;
    byp_set  = 1'b0;
    if (fire) begin
      if (bypass) begin
        hit_kind = CMD_PROGRAM;
        st_d     = SQ_IDLE;
      end else begin
        st_d = SQ_IDLE;
        case (st_q)
          SQ_IDLE: begin
            if (cyc.key_a)                   st_d = SQ_PAIR1;
            else if (cyc.code == CODE_SUSPEND) hit_kind = CMD_SUSPEND;
            else if (cyc.code == CODE_EXIT)    hit_kind = CMD_ID_EXIT;
            else if (cyc.code == CODE_SECTOR)  hit_kind = CMD_RESUME;
          end
          SQ_PAIR1: if (cyc.key_b) st_d = SQ_PAIR2;
          SQ_PAIR2: begin
            if (cyc.at_cmd) begin
              case (cyc.code)
                CODE_PROGRAM:  st_d = SQ_PGM;
                CODE_SETUP:    st_d = SQ_SETUP;
                CODE_ID_ENTER: hit_kind = CMD_ID_ENTER;
                CODE_EXIT:     hit_kind = CMD_ID_EXIT;
                default:       st_d = SQ_IDLE;
              endcase
            end
          end
          SQ_PGM:   hit_kind = CMD_PROGRAM;
          SQ_SETUP: if (cyc.key_a) st_d = SQ_PAIR3;
          SQ_PAIR3: if (cyc.key_b) st_d = SQ_PAIR4;
          SQ_PAIR4: begin
            if (cyc.code == CODE_SECTOR)                 hit_kind = CMD_SECT_ERASE;
            else if (cyc.code == CODE_LOCK)              hit_kind = CMD_LOCKOUT;
            else if (cyc.at_cmd && cyc.code == CODE_CHIP) hit_kind = CMD_CHIP_ERASE;
            else if (cyc.at_cmd && cyc.code == CODE_PROGRAM) byp_set = 1'b1;
          end
          default: st_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      bypass <= 1'b0;
    end else begin
      st_q <= st_d;
      if (byp_set) bypass <= 1'b1;
    end
  end

endmodule

// File: rtl/flash_cmd_out.sv
module flash_cmd_out
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_e          hit_kind,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          cmd_valid,
  output logic [3:0]    cmd_kind,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          id_mode
);

  logic hit;
  assign hit = (hit_kind != CMD_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_kind  <= CMD_NONE;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      id_mode   <= 1'b0;
    end else begin
      cmd_valid <= hit;
      cmd_kind  <= hit_kind;
      if (hit) begin
        cmd_addr <= addr;
        cmd_data <= data;
      end
      if (hit_kind == CMD_ID_ENTER)     id_mode <= 1'b1;
      else if (hit_kind == CMD_ID_EXIT) id_mode <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] ADDR_CMD = 16'h5555,
  parameter logic [AW-1:0] ADDR_ALT = 16'h2AAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  output logic          cmd_valid,
  output logic [3:0]    cmd_kind,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          id_mode,
  output logic          bypass_mode
);

  cyc_t cyc;
  cmd_e hit_kind;
  logic fire;

  assign fire = wr_valid && !busy;

  flash_cmd_match #(.AW(AW), .ADDR_CMD(ADDR_CMD), .ADDR_ALT(ADDR_ALT)) u_match (
    .addr (wr_addr),
    .code (wr_data[7:0]),
    .cyc  (cyc)
  );

  flash_cmd_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .cyc      (cyc),
    .hit_kind (hit_kind),
    .bypass   (bypass_mode)
  );

  flash_cmd_out #(.AW(AW), .DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_kind  (hit_kind),
    .addr      (wr_addr),
    .data      (wr_data),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .id_mode   (id_mode)
  );

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          busy,
  input logic          cmd_valid,
  input logic [3:0]    cmd_kind,
  input logic [AW-1:0] cmd_addr,
  input logic [DW-1:0] cmd_data,
  input logic          id_mode,
  input logic          bypass_mode
);

  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy) |=> !cmd_valid);

  assert_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !cmd_valid);

  assert_kind_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_kind != 4'd0 && cmd_kind <= 4'd8));

  assert_bypass_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_mode |=> bypass_mode);

  assert_bypass_prog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_mode && wr_valid && !busy) |=>
      (cmd_valid && cmd_kind == 4'd1 && cmd_addr == $past(wr_addr) && cmd_data == $past(wr_data)));

  assert_id_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> (cmd_valid && cmd_kind == 4'd5));

  assert_id_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> (cmd_valid && cmd_kind == 4'd6));

endmodule

bind flash_cmd_decoder flash_cmd_checker #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic        cmd_valid;
  logic [3:0]  cmd_kind;
  logic [15:0] cmd_addr;
  logic [7:0]  cmd_data;
  logic        id_mode;
  logic        bypass_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int          m_st;
  bit          m_byp, m_id;
  bit          e_v;
  logic [3:0]  e_k;
  logic [15:0] e_a;
  logic [7:0]  e_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .id_mode(id_mode),
    .bypass_mode(bypass_mode)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Reference model: advances one presented write, gives the expected strobe.
  task automatic model_step(input logic v, input logic [15:0] a,
                            input logic [7:0] d, input logic b);
    bit k1, k2, c;
    e_v = 0; e_k = 0; e_a = a; e_d = d;
    if (!v || b) return;
    k1 = (a == 16'h5555 && d == 8'hAA);
    k2 = (a == 16'h2AAA && d == 8'h55);
    c  = (a == 16'h5555);
    if (m_byp) begin
      e_v = 1; e_k = 1; m_st = 0; return;
    end
    case (m_st)
      0: begin
        m_st = k1 ? 1 : 0;
        if (!k1) begin
          if (d == 8'hB0) begin e_v = 1; e_k = 7; end
          else if (d == 8'hF0) begin e_v = 1; e_k = 6; end
          else if (d == 8'h30) begin e_v = 1; e_k = 8; end
        end
      end
      1: m_st = k2 ? 2 : 0;
      2: begin
        m_st = 0;
        if (c && d == 8'hA0) m_st = 3;
        else if (c && d == 8'h80) m_st = 4;
        else if (c && d == 8'h90) begin e_v = 1; e_k = 5; end
        else if (c && d == 8'hF0) begin e_v = 1; e_k = 6; end
      end
      3: begin m_st = 0; e_v = 1; e_k = 1; end
      4: m_st = k1 ? 5 : 0;
      5: m_st = k2 ? 6 : 0;
      default: begin
        m_st = 0;
        if (d == 8'h30) begin e_v = 1; e_k = 2; end
        else if (d == 8'h40) begin e_v = 1; e_k = 4; end
        else if (c && d == 8'h10) begin e_v = 1; e_k = 3; end
        else if (c && d == 8'hA0) m_byp = 1;
      end
    endcase
    if (e_v && e_k == 5) m_id = 1;
    if (e_v && e_k == 6) m_id = 0;
  endtask

  task automatic cyc(input logic v, input logic [15:0] a, input logic [7:0] d,
                     input logic b, input string tag);
    wr_valid = v; wr_addr = a; wr_data = d; busy = b;
    model_step(v, a, d, b);
    @(posedge clk);
    @(negedge clk);
    chk(cmd_valid === e_v, tag, "cmd_valid", cmd_valid, e_v);
    if (e_v) begin
      chk(cmd_kind === e_k, tag, "cmd_kind", cmd_kind, e_k);
      chk(cmd_addr === e_a, tag, "cmd_addr", cmd_addr, e_a);
      chk(cmd_data === e_d, tag, "cmd_data", cmd_data, e_d);
    end
    chk(id_mode === m_id, tag, "id_mode", id_mode, m_id);
    chk(bypass_mode === m_byp, tag, "bypass_mode", bypass_mode, m_byp);
  endtask

  task automatic do_reset();
    rst_n = 0; wr_valid = 0; busy = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst_n = 1;
    m_st = 0; m_byp = 0; m_id = 0;
    chk(cmd_valid === 1'b0, "R1", "cmd_valid", cmd_valid, 0);
    chk(id_mode === 1'b0, "R1", "id_mode", id_mode, 0);
    chk(bypass_mode === 1'b0, "R1", "bypass_mode", bypass_mode, 0);
  endtask

  task automatic prefix5(input string tag);
    cyc(1, 16'h5555, 8'hAA, 0, tag);
    cyc(1, 16'h2AAA, 8'h55, 0, tag);
    cyc(1, 16'h5555, 8'h80, 0, tag);
    cyc(1, 16'h5555, 8'hAA, 0, tag);
    cyc(1, 16'h2AAA, 8'h55, 0, tag);
  endtask

  // Biased generator: mostly the next legal step of the model's sequence.
  task automatic gen(output logic [15:0] a, output logic [7:0] d);
    logic [7:0] pool [10] = '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h90, 8'hF0,
                              8'h30, 8'h10, 8'h40, 8'hB0};
    a = 16'($urandom);
    d = 8'($urandom);
    if ($urandom % 10 < 6 && !m_byp) begin
      case (m_st)
        0: begin
          case ($urandom % 4)
            0: d = 8'hB0;
            1: d = 8'hF0;
            2: d = 8'h30;
            default: begin a = 16'h5555; d = 8'hAA; end
          endcase
        end
        1, 5: begin a = 16'h2AAA; d = 8'h55; end
        2: begin
          a = 16'h5555;
          case ($urandom % 4)
            0: d = 8'hA0;
            1: d = 8'h80;
            2: d = 8'h90;
            default: d = 8'hF0;
          endcase
        end
        3: ;
        4: begin a = 16'h5555; d = 8'hAA; end
        default: begin
          case ($urandom % 8)
            0: begin a = 16'h5555; d = 8'hA0; end
            1, 2: begin a = 16'h5555; d = 8'h10; end
            3, 4: d = 8'h40;
            default: d = 8'h30;
          endcase
        end
      endcase
    end else if ($urandom % 2 == 0) begin
      d = pool[$urandom % 10];
      if ($urandom % 2 == 0) a = ($urandom % 2 == 0) ? 16'h5555 : 16'h2AAA;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    // R2 program
    cyc(1, 16'h5555, 8'hAA, 0, "R2");
    cyc(1, 16'h2AAA, 8'h55, 0, "R2");
    cyc(1, 16'h5555, 8'hA0, 0, "R2");
    cyc(1, 16'h1234, 8'h77, 0, "R2");
    chk(cmd_kind === 4'd1 && cmd_addr === 16'h1234, "R2", "program strobe", cmd_kind, 1);

    // R3 sector erase, R4 chip erase, R5 lockout
    prefix5("R3");
    cyc(1, 16'h4321, 8'h30, 0, "R3");
    prefix5("R4");
    cyc(1, 16'h5555, 8'h10, 0, "R4");
    prefix5("R5");
    cyc(1, 16'h7000, 8'h40, 0, "R5");

    // R6 identification entry and both exit forms
    cyc(1, 16'h5555, 8'hAA, 0, "R6");
    cyc(1, 16'h2AAA, 8'h55, 0, "R6");
    cyc(1, 16'h5555, 8'h90, 0, "R6");
    chk(id_mode === 1'b1, "R6", "id_mode after entry", id_mode, 1);
    cyc(1, 16'h0ABC, 8'hF0, 0, "R6");
    cyc(1, 16'h5555, 8'hAA, 0, "R6");
    cyc(1, 16'h2AAA, 8'h55, 0, "R6");
    cyc(1, 16'h5555, 8'h90, 0, "R6");
    cyc(1, 16'h5555, 8'hAA, 0, "R6");
    cyc(1, 16'h2AAA, 8'h55, 0, "R6");
    cyc(1, 16'h5555, 8'hF0, 0, "R6");
    chk(id_mode === 1'b0, "R6", "id_mode after exit", id_mode, 0);

    // R7 suspend and resume
    cyc(1, 16'h1111, 8'hB0, 0, "R7");
    cyc(1, 16'hC000, 8'h30, 0, "R7");

    // R10 mismatches return to idle with no strobe
    cyc(1, 16'h5555, 8'hAA, 0, "R10");
    cyc(1, 16'h2AAA, 8'h55, 0, "R10");
    cyc(1, 16'h5555, 8'h77, 0, "R10");
    cyc(1, 16'h5555, 8'hA0, 0, "R10");
    cyc(1, 16'h3333, 8'h12, 0, "R10");
    cyc(1, 16'h5555, 8'hAA, 0, "R10");
    cyc(1, 16'h2AAB, 8'h55, 0, "R10");
    cyc(1, 16'h5555, 8'hAA, 0, "R10");
    cyc(1, 16'h2AAA, 8'hB0, 0, "R10");
    chk(cmd_valid === 1'b0, "R10", "no suspend from mismatch", cmd_valid, 0);

    // R9 busy drops writes and keeps position
    cyc(1, 16'h5555, 8'hAA, 0, "R9");
    cyc(1, 16'h9999, 8'h01, 1, "R9");
    cyc(1, 16'h2AAA, 8'h55, 0, "R9");
    cyc(1, 16'h1111, 8'hB0, 1, "R9");
    cyc(1, 16'h5555, 8'hA0, 0, "R9");
    cyc(1, 16'h0F0F, 8'h5A, 0, "R9");
    cyc(1, 16'h2222, 8'hB0, 1, "R9");

    // R11 idle cycles give no strobe
    cyc(0, 16'h1111, 8'hB0, 0, "R11");
    cyc(0, 16'h5555, 8'hAA, 0, "R11");

    // R8 fast-program mode
    prefix5("R8");
    cyc(1, 16'h5555, 8'hA0, 0, "R8");
    chk(bypass_mode === 1'b1, "R8", "bypass set", bypass_mode, 1);
    cyc(1, 16'h0100, 8'hB0, 0, "R8");
    cyc(1, 16'h0200, 8'h30, 0, "R8");
    cyc(1, 16'h5555, 8'h80, 0, "R8");
    cyc(1, 16'h0300, 8'hF0, 0, "R8");
    cyc(1, 16'h5555, 8'hAA, 0, "R8");
    cyc(1, 16'h0400, 8'h10, 1, "R8");
    cyc(0, 16'h0400, 8'h10, 0, "R8");
    do_reset();
    chk(bypass_mode === 1'b0, "R8", "reset clears bypass", bypass_mode, 0);

    // Random stream against the model, with periodic resets
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] ra;
      logic [7:0]  rd;
      if (i % 300 == 299) do_reset();
      gen(ra, rd);
      cyc(($urandom % 8) != 0, ra, rd, ($urandom % 10) == 0, "R11 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule